// File: doc/BRIEF.md
# Addressed Three-Wire Register Loader

This block is a write-only serial configuration port. A host drives three slow lines: a serial clock, a serial data line and a load strobe. All three are sampled by a much faster system clock. Data bits are taken on serial clock rising edges, most significant bit first, into a 24-bit shift register. When the strobe rises, the two top bits of that register pick one of four 22-bit control registers, and the low 22 bits are copied into it.

Each control register has a one-cycle update pulse, so downstream logic can react to a fresh value. The port is never gated by any operating mode, and a single register can be rewritten without touching the other three. If the host clocks in more than 24 bits before a load, only the most recent 24 are kept. If it clocks in fewer, the load still commits whatever the shift register holds.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each synchronised rising edge of `serClk` while the strobe is low, `serData` is shifted into bit 0 of the 24-bit shift register and every earlier bit moves up one place, so the first bit sent ends at bit 23.
- R2: When more than 24 bits are clocked in before a load, only the 24 most recent bits are kept.
- R3: A committed word uses bits 23:22 as the register address (00 gives `regA`, 01 gives `regB`, 10 gives `regC`, 11 gives `regD`) and bits 21:0 as the data.
- R4: A rising edge of `serStrobe` copies the data field into the addressed register only; the other three registers keep their values.
- R5: `updPulse[i]` (bit 0 for `regA` through bit 3 for `regD`) is high for exactly one system clock, in the cycle in which the new value of register i is first visible, and at most one bit is high at a time.
- R6: Serial clock rising edges that occur while the strobe is high do not change the shift register.
- R7: A load with fewer than 24 bits sent since the previous load commits the shift register's current contents, which include the older bits still held.
- R8: A synchronous active-high `rst` clears the shift register, all four registers and all update pulses to zero.
- R9: Each serial input passes through a two-flop synchroniser on `clk`, and operation is correct when `clk` runs at least four times faster than `serClk`, with each serial level held for at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial clock, asynchronous to `clk` |
| serData | input | 1 | Serial data, MSB first |
| serStrobe | input | 1 | Load strobe; its rising edge commits the word |
| regA | output | 22 | Control register at address 00 |
| regB | output | 22 | Control register at address 01 |
| regC | output | 22 | Control register at address 10 |
| regD | output | 22 | Control register at address 11 |
| updPulse | output | 4 | One-cycle update pulse per register |

## Verification
The bench sends words that are too long, too short and exact, and each kind lands in a different register. A design that kept the oldest bits would load the leading junk of an overlong word. One that cleared the shifter on each load would commit zeros in place of the older bits left over after a short word. Serial clock pulses sent while the strobe is high must leave the shifter unchanged, so a following empty load has to repeat the previous word; a design that shifted on those edges would load ones instead. Every cycle, all four registers are compared with a shadow copy, which catches a write to an unaddressed register, an update pulse that lasts two cycles, and a reset applied mid-run that fails to clear a value.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int CFG_DATA_W = 22;
  localparam int CFG_ADDR_W = 2;

  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;   // take one serial bit this cycle
    logic shiftBit;  // value of that bit
    logic loadEn;    // commit the shift register to the addressed register
  } cfgStrobes_t;

endpackage

// File: rtl/cfg_input_sync.sv
module cfg_input_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import serial_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sClk,
  input  logic        sData,
  input  logic        sStrobe,
  output cfgStrobes_t strobes
);

  logic prevClk;
  logic prevStrobe;
  logic clkRise;
  logic strobeRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevClk    <= 1'b0;
      prevStrobe <= 1'b0;
    end else begin
      prevClk    <= sClk;
      prevStrobe <= sStrobe;
    end
  end

  assign clkRise    = sClk & ~prevClk;
  assign strobeRise = sStrobe & ~prevStrobe;

  always_comb begin
    strobes          = '0;
    strobes.shiftEn  = clkRise & ~sStrobe;  // edges while the strobe is high are dropped
    strobes.shiftBit = sData;
    strobes.loadEn   = strobeRise;
  end

  // R4: a strobe edge produces a single load command
  p_single_load_r4: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEn |=> !strobes.loadEn);

  // R6: no shift command accompanies a load command
  p_no_shift_on_load_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEn |-> !strobes.shiftEn);

endmodule

// File: rtl/cfg_loader_datapath.sv
module cfg_loader_datapath
  import serial_cfg_pkg::*;
#(
  parameter int DATA_W = CFG_DATA_W,
  parameter int ADDR_W = CFG_ADDR_W,
  localparam int WORD_W   = DATA_W + ADDR_W,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  cfgStrobes_t                        strobes,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regFile,
  output logic [NUM_REGS-1:0]                updPulse
);

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] loadAddr;
  logic [DATA_W-1:0] loadData;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strobes.shiftBit};
    end
  end

  assign loadAddr = shiftReg[WORD_W-1 -: ADDR_W];
  assign loadData = shiftReg[DATA_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hit;
    assign hit = strobes.loadEn && (loadAddr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        regFile[g]  <= '0;
        updPulse[g] <= 1'b0;
      end else begin
        updPulse[g] <= hit;
        if (hit) begin
          regFile[g] <= loadData;
        end
      end
    end

    // R4: a register without its pulse keeps its value
    p_unaddressed_stable_r4: assert property (@(posedge clk) disable iff (rst)
      !updPulse[g] |-> $stable(regFile[g]));

    // R3: a pulsing register holds the data field of the word before the load
    p_loaded_value_r3: assert property (@(posedge clk) disable iff (rst)
      updPulse[g] |-> regFile[g] == $past(shiftReg[DATA_W-1:0]));
  end

  // R1: the shifter only moves on a shift command
  p_shift_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> $stable(shiftReg));

  // R2: a shift drops the top bit and keeps the next 23
  p_shift_window_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> shiftReg[WORD_W-1:1] == $past(shiftReg[WORD_W-2:0]));

  // R5: at most one pulse, never two cycles in a row
  p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(updPulse));
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    (updPulse != '0) |=> (updPulse == '0));

  // R8: reset leaves everything at zero
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (regFile == '0 && updPulse == '0 && shiftReg == '0));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int DATA_W      = CFG_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serStrobe,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic [DATA_W-1:0] regD,
  output logic [3:0]        updPulse
);

  localparam int ADDR_W   = 2;
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [2:0]                      syncBus;
  cfgStrobes_t                     strobes;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;

  // R9: all three serial lines cross into the system clock domain together
  cfg_input_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({serStrobe, serData, serClk}),
    .syncOut (syncBus)
  );

  cfg_loader_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .sClk    (syncBus[0]),
    .sData   (syncBus[1]),
    .sStrobe (syncBus[2]),
    .strobes (strobes)
  );

  cfg_loader_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .regFile  (regFile),
    .updPulse (updPulse)
  );

  assign regA = regFile[0];
  assign regB = regFile[1];
  assign regC = regFile[2];
  assign regD = regFile[3];

endmodule

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serStrobe = 1'b0;
  logic [21:0] regA, regB, regC, regD;
  logic [3:0]  updPulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [23:0] shiftModel = '0;
  logic [21:0] shadow [4];
  logic [23:0] expQ [$];

  always #2.5 clk = ~clk;

  serial_cfg_loader dut (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData), .serStrobe(serStrobe),
    .regA(regA), .regB(regB), .regC(regC), .regD(regD), .updPulse(updPulse)
  );

  function automatic logic [21:0] regOut(int idx);
    case (idx)
      0: return regA;
      1: return regB;
      2: return regC;
      default: return regD;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 R9: one serial bit, each level held three system clocks
  task automatic sendBit(logic b);
    @(negedge clk);
    serData = b;
    serClk  = 1'b0;
    waitCycles(3);
    serClk = 1'b1;
    if (!serStrobe) shiftModel = {shiftModel[22:0], b};
    waitCycles(3);
    serClk = 1'b0;
  endtask

  task automatic sendBits(logic [31:0] val, int n);
    for (int i = n - 1; i >= 0; i--) sendBit(val[i]);
  endtask

  task automatic strobeRise();
    @(negedge clk);
    expQ.push_back(shiftModel);
    serStrobe = 1'b1;
    waitCycles(4);
  endtask

  task automatic strobeFall();
    @(negedge clk);
    serStrobe = 1'b0;
    waitCycles(4);
  endtask

  task automatic loadWord(logic [1:0] addr, logic [21:0] data);
    sendBits({8'h0, addr, data}, 24);
    strobeRise();
    strobeFall();
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    waitCycles(3);
    rst = 1'b0;
    shiftModel = '0;
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    expQ.delete();
    waitCycles(1);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (updPulse != 4'b0) begin
        if (expQ.size() == 0) begin
          check("R5 unexpected pulse", {28'h0, updPulse}, 32'h0);
        end else begin
          logic [23:0] w;
          w = expQ.pop_front();
          check("R3 R5 pulse select", {28'h0, updPulse}, 32'(4'b1 << w[23:22]));
          shadow[w[23:22]] = w[21:0];
          check("R3 R4 loaded value", {10'h0, regOut(int'(w[23:22]))}, {10'h0, w[21:0]});
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (regOut(i) !== shadow[i])
          check("R4 R8 register shadow", {10'h0, regOut(i)}, {10'h0, shadow[i]});
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    waitCycles(4);
    // R8: state after power-up reset
    check("R8 reset regs", {10'h0, regA | regB | regC | regD}, 32'h0);
    check("R8 reset pulse", {28'h0, updPulse}, 32'h0);
    rst = 1'b0;
    waitCycles(2);

    // R1 R3 R4: one word to every address
    loadWord(2'b00, 22'h2AAAAA);
    loadWord(2'b01, 22'h155555);
    loadWord(2'b10, 22'h3F0F0F);
    loadWord(2'b11, 22'h00FF33);
    check("R3 regA", {10'h0, regA}, 32'h2AAAAA);
    check("R3 regD", {10'h0, regD}, 32'h00FF33);

    // R2: six leading junk ones, then a word for A
    sendBits(32'h3F, 6);
    sendBits({8'h0, 2'b00, 22'h012345}, 24);
    strobeRise();
    strobeFall();
    check("R2 overlong word", {10'h0, regA}, 32'h012345);

    // R4: rewrite only B
    loadWord(2'b01, 22'h3FFFFF);
    check("R4 C untouched", {10'h0, regC}, 32'h3F0F0F);

    // R7: only eight bits before the load
    sendBits(32'hA5, 8);
    strobeRise();
    strobeFall();

    // R6: serial clocks with ones while the strobe is high
    loadWord(2'b10, 22'h000001);
    strobeRise();
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    strobeFall();
    strobeRise();
    strobeFall();
    check("R6 ignored edges", {10'h0, regC}, 32'h000001);

    // R8: reset in mid-run, then a fresh load to D
    applyReset();
    check("R8 mid reset", {10'h0, regA | regB | regC | regD}, 32'h0);
    loadWord(2'b11, 22'h2C3A5B);
    check("R3 post reset D", {10'h0, regD}, 32'h2C3A5B);

    waitCycles(10);
    check("R5 scoreboard drained", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule